// File: doc/BRIEF.md
# Configurable CRC Engine with Register Bus

This block computes a running cyclic redundancy check over data that software or a DMA channel writes into it through a small register bus. The bus has four word registers: control, seed, checksum and data. A write to the seed register loads the running CRC. Every later write to the data register folds the bytes enabled by the byte strobes into that value, one byte after another. A full word, such as a DMA channel writing repeatedly to one fixed address, contributes four bytes. A single-strobe write contributes one byte, so leftover bytes at the end of a buffer can be sent after the words. The result is read from the checksum register.

The control register selects one of three polynomials. CRC-16-CCITT (0x1021) and CRC-16 (0x8005) use a 16-bit state, and CRC-32 (0x04C11DB7) uses a 32-bit state. The control register also holds two independent groups of transforms. The input group can complement the incoming bytes, reverse the bits inside each byte, and reverse the processing order of the enabled lanes. The output group can complement the checksum, swap its bytes, and reverse its bits. The output group only changes how the checksum is read. It never changes the stored state. With these transforms, both reflected and non-reflected CRC variants can be computed.

The register bus is a plain single-cycle interface. Reads are combinational from the address, and writes take effect at the clock edge. The bus has no valid/ready handshake. There is no back-pressure, because the whole word update finishes in one cycle: a new data write can be accepted on every clock edge, and no write is ever refused.

Top module: `crcx_engine`

## Requirements
- R1: After reset, the control, seed and checksum registers read as zero, and the data address reads as zero at all times.
- R2: The control register is written through byte lane 0 and holds 8 bits. Bits 31:8 always read zero. Field positions: bit 7 is output complement, bit 6 is output byte swap, bit 5 is output bit reverse, bit 4 is input complement, bit 3 is input lane-order reverse, bit 2 is input per-byte bit reverse, and bits 1:0 are the polynomial select.
- R3: A write to the seed register (byte address 0x4) stores the strobed bytes. It also loads the merged value directly into the running CRC, and the seed reads back at 0x4.
- R4: With no transforms, a data write (address 0xC) with all four strobes set processes the bytes from the most significant lane down to the least significant. Each byte is applied MSB-first with a non-reflected shift. The new checksum is readable in the cycle after the write.
- R5: Polynomial select 00 gives 0x1021 over 16 bits, 01 gives 0x8005 over 16 bits, and 10 or 11 give 0x04C11DB7 over 32 bits. In the 16-bit modes the checksum bits 31:16 read zero.
- R6: Only lanes whose strobe is set are processed. A data write with no strobe leaves the CRC unchanged. Word and byte writes mixed in one stream give the same result as feeding the same bytes one at a time.
- R7: Input transforms. Bit 4 inverts each byte. Bit 2 reverses the bit order within each byte. Bit 3 makes the enabled lanes be processed from the least significant lane upward.
- R8: Output transforms act on the CRC width. Bit 7 inverts it, bit 6 swaps its bytes end for end, and bit 5 reverses its bits. Reading the checksum never alters the running state.
- R9: Data writes on consecutive clock cycles are each absorbed, with no wait state.
- R10: Writes to the checksum address, and cycles with no write, leave the running CRC unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (4) | Byte address of the register |
| bus_we | input | 1 | Write enable for this cycle |
| bus_strb | input | BUS_W/8 (4) | Byte lane strobes of the write |
| bus_wdata | input | BUS_W (32) | Write data |
| bus_rdata | output | BUS_W (32) | Read data for bus_addr, combinational |

## Verification
The engine is swept over every polynomial select combined with every one of the 64 transform settings. Each setting uses one stream that mixes a full word, a two-lane write and single-lane writes at both ends of the word. This separates the lane-order and strobe handling from the polynomial arithmetic. An exhaustive pass feeds all 256 byte values into each polynomial through a rotating single lane, which isolates the byte step and the lane selection. Known check values for three common CRC variants over "123456789" confirm that the transforms combine into standard reflected and non-reflected forms. Separate patterns cover writes that must do nothing: a zero strobe, a write to the checksum address, and repeated reads.

// File: rtl/crcx_pkg.sv
package crcx_pkg;

  localparam int CRC_W = 32;

  typedef struct packed {
    logic       out_inv;
    logic       out_swap;
    logic       out_refl;
    logic       in_inv;
    logic       in_swap;
    logic       in_refl;
    logic [1:0] poly_sel;
  } crcx_ctrl_t;

  function automatic logic [CRC_W-1:0] poly_of(input logic [1:0] sel);
    logic [CRC_W-1:0] p;
    if (sel[1])      p = 32'h04C1_1DB7;
    else if (sel[0]) p = 32'h0000_8005;
    else             p = 32'h0000_1021;
    return p;
  endfunction

  // one byte folded into the state, MSB first, state width 16 or 32
  function automatic logic [CRC_W-1:0] fold_byte(input logic [CRC_W-1:0] st,
                                                 input logic [7:0] b,
                                                 input logic wide,
                                                 input logic [CRC_W-1:0] poly);
    logic [CRC_W-1:0] r;
    r = wide ? st : {16'h0000, st[15:0]};
    if (wide) r[31:24] = r[31:24] ^ b;
    else      r[15:8]  = r[15:8] ^ b;
    for (int i = 0; i < 8; i++) begin
      if (wide ? r[31] : r[15]) r = (r << 1) ^ poly;
      else                      r = r << 1;
    end
    if (!wide) r[31:16] = 16'h0000;
    return r;
  endfunction

endpackage

// File: rtl/crcx_in_prep.sv
module crcx_in_prep #(
  parameter int LANES = 4
) (
  input  logic [LANES*8-1:0]      data,
  input  logic [LANES-1:0]        strb,
  input  logic                    inv,
  input  logic                    swap,
  input  logic                    refl,
  output logic [LANES-1:0][7:0]   ord_byte,
  output logic [LANES-1:0]        ord_vld
);
  logic [LANES-1:0][7:0] lane_b;

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [7:0] raw, flip;
      assign raw = data[l*8 +: 8] ^ {8{inv}};
      for (genvar b = 0; b < 8; b++) begin : g_bit
        assign flip[b] = raw[7-b];
      end
      assign lane_b[l] = refl ? flip : raw;
    end
    // slot 0 is folded first
    for (genvar k = 0; k < LANES; k++) begin : g_ord
      localparam int UP = k;
      localparam int DN = LANES - 1 - k;
      assign ord_byte[k] = swap ? lane_b[UP] : lane_b[DN];
      assign ord_vld[k]  = swap ? strb[UP]   : strb[DN];
    end
  endgenerate
endmodule

// File: rtl/crcx_step_chain.sv
module crcx_step_chain
  import crcx_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic [CRC_W-1:0]        crc_in,
  input  logic [LANES-1:0][7:0]   ord_byte,
  input  logic [LANES-1:0]        ord_vld,
  input  logic [1:0]              poly_sel,
  output logic [CRC_W-1:0]        crc_out
);
  logic [LANES:0][CRC_W-1:0] stage;
  logic [CRC_W-1:0]          poly;

  assign poly     = poly_of(poly_sel);
  assign stage[0] = crc_in;

  generate
    for (genvar k = 0; k < LANES; k++) begin : g_step
      assign stage[k+1] = ord_vld[k]
                        ? fold_byte(stage[k], ord_byte[k], poly_sel[1], poly)
                        : stage[k];
    end
  endgenerate

  assign crc_out = stage[LANES];
endmodule

// File: rtl/crcx_out_xform.sv
module crcx_out_xform
  import crcx_pkg::*;
(
  input  logic [CRC_W-1:0] crc,
  input  logic             wide,
  input  logic             inv,
  input  logic             swap,
  input  logic             refl,
  output logic [CRC_W-1:0] sum
);
  logic [CRC_W-1:0] a, b;

  always_comb begin
    a = wide ? (crc ^ {CRC_W{inv}}) : {16'h0000, crc[15:0] ^ {16{inv}}};
    b = a;
    if (swap) b = wide ? {a[7:0], a[15:8], a[23:16], a[31:24]}
                       : {16'h0000, a[7:0], a[15:8]};
    sum = b;
    if (refl) begin
      sum = '0;
      for (int i = 0; i < CRC_W; i++) begin
        if (wide)        sum[i] = b[CRC_W-1-i];
        else if (i < 16) sum[i] = b[15-i];
      end
    end
  end
endmodule

// File: rtl/crcx_engine.sv
module crcx_engine
  import crcx_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int BUS_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [BUS_W/8-1:0] bus_strb,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata
);
  localparam int LANES = BUS_W / 8;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_SEED = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_SUM  = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(12);

  crcx_ctrl_t              ctrl_q;
  logic [BUS_W-1:0]        seed_q, seed_nx;
  logic [CRC_W-1:0]        crc_q, crc_nx, sum;
  logic [LANES-1:0][7:0]   ord_byte;
  logic [LANES-1:0]        ord_vld;
  logic                    wide;

  assign wide = ctrl_q.poly_sel[1];

  always_comb begin
    seed_nx = seed_q;
    for (int l = 0; l < LANES; l++)
      if (bus_strb[l]) seed_nx[l*8 +: 8] = bus_wdata[l*8 +: 8];
  end

  crcx_in_prep #(.LANES(LANES)) u_prep (
    .data     (bus_wdata),
    .strb     (bus_strb),
    .inv      (ctrl_q.in_inv),
    .swap     (ctrl_q.in_swap),
    .refl     (ctrl_q.in_refl),
    .ord_byte (ord_byte),
    .ord_vld  (ord_vld)
  );

  crcx_step_chain #(.LANES(LANES)) u_chain (
    .crc_in   (crc_q),
    .ord_byte (ord_byte),
    .ord_vld  (ord_vld),
    .poly_sel (ctrl_q.poly_sel),
    .crc_out  (crc_nx)
  );

  crcx_out_xform u_out (
    .crc  (crc_q),
    .wide (wide),
    .inv  (ctrl_q.out_inv),
    .swap (ctrl_q.out_swap),
    .refl (ctrl_q.out_refl),
    .sum  (sum)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      seed_q <= '0;
      crc_q  <= '0;
    end else if (bus_we) begin
      if (bus_addr == A_CTRL && bus_strb[0]) ctrl_q <= crcx_ctrl_t'(bus_wdata[7:0]);
      if (bus_addr == A_SEED) begin
        seed_q <= seed_nx;
        crc_q  <= CRC_W'(seed_nx);
      end
      if (bus_addr == A_DATA) crc_q <= crc_nx;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_CTRL)      bus_rdata = BUS_W'(ctrl_q);
    else if (bus_addr == A_SEED) bus_rdata = seed_q;
    else if (bus_addr == A_SUM)  bus_rdata = BUS_W'(sum);
  end
endmodule

// File: rtl/crcx_engine_chk.sv
module crcx_engine_chk #(
  parameter int ADDR_W = 4,
  parameter int BUS_W  = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               bus_we,
  input logic [BUS_W/8-1:0] bus_strb,
  input logic [BUS_W-1:0]   bus_wdata,
  input logic [BUS_W-1:0]   bus_rdata,
  input logic [31:0]        crc_q,
  input logic               poly_wide
);
  // R2: reserved control bits read zero
  p_ctrl_rsvd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(0)) |-> (bus_rdata[BUS_W-1:8] == '0));

  // R5: narrow polynomials leave upper checksum bits clear
  p_narrow_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(8) && !poly_wide) |-> (bus_rdata[31:16] == 16'h0000));

  // R3: full-strobe seed write loads the running CRC
  p_seed_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(4) && bus_strb == '1) |=> (crc_q == $past(bus_wdata)));

  // R10: idle cycles keep the state
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_we) |=> $stable(crc_q));

  // R10: checksum address is not writable
  p_sum_ro_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(8)) |=> $stable(crc_q));

  // R6: data write with no lane enabled does nothing
  p_no_lane_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(12) && bus_strb == '0) |=> $stable(crc_q));
endmodule

bind crcx_engine crcx_engine_chk #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_strb  (bus_strb),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .crc_q     (crc_q),
  .poly_wide (wide)
);

// File: tb/crcx_engine_tb.sv
`timescale 1ns/1ps
module crcx_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_strb = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  crcx_engine u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_strb(bus_strb), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  // ---------------- reference model ----------------
  function automatic logic [31:0] m_step(input logic [31:0] c, input logic [7:0] b,
                                         input logic [1:0] p);
    int w;
    logic [31:0] poly, msk;
    logic fb;
    w    = p[1] ? 32 : 16;
    poly = p[1] ? 32'h04C11DB7 : (p[0] ? 32'h8005 : 32'h1021);
    msk  = p[1] ? 32'hFFFFFFFF : 32'h0000FFFF;
    c = c & msk;
    for (int i = 7; i >= 0; i--) begin
      fb = c[w-1] ^ b[i];
      c  = (c << 1) & msk;
      if (fb) c = c ^ poly;
    end
    return c;
  endfunction

  function automatic logic [31:0] m_feed(input logic [31:0] c, input logic [31:0] d,
                                         input logic [3:0] s, input logic [7:0] ctl);
    logic [7:0] b, r;
    int ln;
    for (int k = 0; k < 4; k++) begin
      ln = ctl[3] ? k : 3 - k;
      if (s[ln]) begin
        b = d[ln*8 +: 8];
        if (ctl[4]) b = ~b;
        if (ctl[2]) begin
          for (int i = 0; i < 8; i++) r[i] = b[7-i];
          b = r;
        end
        c = m_step(c, b, ctl[1:0]);
      end
    end
    return c;
  endfunction

  function automatic logic [31:0] m_out(input logic [31:0] c, input logic [7:0] ctl);
    logic [31:0] v, r;
    int w;
    w = ctl[1] ? 32 : 16;
    v = ctl[1] ? c : (c & 32'hFFFF);
    if (ctl[7]) v = ctl[1] ? ~v : (~v & 32'hFFFF);
    if (ctl[6]) v = ctl[1] ? {v[7:0], v[15:8], v[23:16], v[31:24]} : {16'h0, v[7:0], v[15:8]};
    if (ctl[5]) begin
      r = '0;
      for (int i = 0; i < w; i++) r[i] = v[w-1-i];
      v = r;
    end
    return v;
  endfunction

  // ---------------- bus tasks ----------------
  task automatic wr(input logic [3:0] a, input logic [3:0] s, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_strb = s; bus_wdata = d;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b0; bus_strb = '0; bus_addr = a;
    #2 d = bus_rdata;
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, v2, mc, sd, w1, w2, w3, w4;
    logic [7:0]  ctl;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(4'h0, v); chk("R1 ctrl", v, 0);
    rd(4'h4, v); chk("R1 seed", v, 0);
    rd(4'h8, v); chk("R1 sum", v, 0);
    rd(4'hC, v); chk("R1 data", v, 0);

    // R2 control width and byte lane
    wr(4'h0, 4'hF, 32'hFFFF_FF5A); rd(4'h0, v); chk("R2 rsvd", v, 32'h5A);
    wr(4'h0, 4'hE, 32'h0000_0011); rd(4'h0, v); chk("R2 lane0", v, 32'h5A);

    // R3 seed readback and load, R10 no-ops
    wr(4'h0, 4'hF, 32'h02);
    wr(4'h4, 4'hF, 32'hDEAD_BEEF); rd(4'h4, v); chk("R3 seed rd", v, 32'hDEADBEEF);
    rd(4'h8, v); chk("R3 seed load", v, 32'hDEADBEEF);
    wr(4'h4, 4'h2, 32'h0000_1200); rd(4'h8, v); chk("R3 strobed seed", v, 32'hDEAD12EF);
    wr(4'h8, 4'hF, 32'h1234_5678); rd(4'h8, v); chk("R10 sum ro", v, 32'hDEAD12EF);
    wr(4'hC, 4'h0, 32'h1234_5678); rd(4'h8, v); chk("R6 no lane", v, 32'hDEAD12EF);
    rd(4'h8, v2); chk("R8 read stable", v2, 32'hDEAD12EF);

    // R4 R7 R8 known check values over "123456789"
    wr(4'h0, 4'hF, 32'hA6); wr(4'h4, 4'hF, 32'hFFFF_FFFF);
    wr(4'hC, 4'hF, 32'h3132_3334); wr(4'hC, 4'hF, 32'h3536_3738); wr(4'hC, 4'h4, 32'h0039_0000);
    rd(4'h8, v); chk("R7 R8 crc32 kat", v, 32'hCBF43926);
    wr(4'h0, 4'hF, 32'h00); wr(4'h4, 4'hF, 32'h0000_FFFF);
    wr(4'hC, 4'hF, 32'h3132_3334); wr(4'hC, 4'hF, 32'h3536_3738); wr(4'hC, 4'h1, 32'h0000_0039);
    rd(4'h8, v); chk("R4 R5 ccitt kat", v, 32'h29B1);
    wr(4'h0, 4'hF, 32'h25); wr(4'h4, 4'hF, 32'h0);
    wr(4'hC, 4'hF, 32'h3132_3334); wr(4'hC, 4'hF, 32'h3536_3738); wr(4'hC, 4'h8, 32'h3900_0000);
    rd(4'h8, v); chk("R5 R7 arc kat", v, 32'hBB3D);
    // R7 lane order reverse gives the same stream
    wr(4'h0, 4'hF, 32'h0A); wr(4'h4, 4'hF, 32'h0);
    wr(4'hC, 4'hF, 32'h3433_3231); wr(4'hC, 4'hF, 32'h3837_3635); wr(4'hC, 4'h4, 32'h0039_0000);
    rd(4'h8, v); chk("R7 lane swap", v, m_feed(m_feed(m_feed(0, 32'h31323334, 4'hF, 8'h02),
                                                    32'h35363738, 4'hF, 8'h02), 32'h39, 4'h1, 8'h02));

    // R6 R7 R8 R9 sweep: every polynomial x every transform setting, back-to-back writes
    for (int p = 0; p < 4; p++) begin
      for (int t = 0; t < 64; t++) begin
        ctl = {t[5:0], p[1:0]};
        sd  = 32'h9E3779B9 * (t + 7) ^ (p << 29);
        w1  = 32'h85EBCA6B * (t + 3) + p;
        w2  = 32'hC2B2AE35 ^ (t * 32'h01010101);
        w3  = w1 ^ 32'h5A5A5A5A;
        w4  = w2 + 32'h13579BDF;
        wr(4'h0, 4'hF, {24'h0, ctl});
        wr(4'h4, 4'hF, sd);
        wr(4'hC, 4'hF, w1);
        wr(4'hC, 4'h6, w2);
        wr(4'hC, 4'h1, w3);
        wr(4'hC, 4'h8, w4);
        mc = m_feed(sd, w1, 4'hF, ctl);
        mc = m_feed(mc, w2, 4'h6, ctl);
        mc = m_feed(mc, w3, 4'h1, ctl);
        mc = m_feed(mc, w4, 4'h8, ctl);
        rd(4'h8, v); chk("R6 R7 R8 R9 sweep", v, m_out(mc, ctl));
        if (t == 21) begin
          rd(4'h8, v); chk("R8 reread", v, m_out(mc, ctl));
          wr(4'hC, 4'hF, w2); mc = m_feed(mc, w2, 4'hF, ctl);
          rd(4'h8, v); chk("R8 state untouched", v, m_out(mc, ctl));
        end
      end
    end

    // R4 R5 R6 exhaustive single-byte values per polynomial, rotating lane
    for (int p = 0; p < 4; p++) begin
      wr(4'h0, 4'hF, p);
      for (int b = 0; b < 256; b++) begin
        sd = {b[7:0], ~b[7:0], b[7:0] ^ 8'h3C, b[7:0]};
        wr(4'h4, 4'hF, sd);
        wr(4'hC, 4'b0001 << (b % 4), {24'h0, b[7:0]} << (8 * (b % 4)));
        rd(4'h8, v);
        chk("R4 R5 R6 byte", v, m_step(sd, b[7:0], p[1:0]) & (p[1] ? 32'hFFFFFFFF : 32'hFFFF));
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule